// File: doc/BRIEF.md
# Key-Gated Watchdog Timer

This block is a watchdog timer behind a simple 32-bit register bus. The bus has an address, a write strobe, write data and read data. A write counts only if its upper half carries a fixed unlock key. Software first writes a prescaler setting, a reload count and an early-warning level into holding (shadow) registers. None of these values touch the running timer until software applies them through a refresh register. That register is split into three 2-bit group codes. Changing a group's code fires that group's action. Software feeds the dog by flipping the counter group's code back and forth between 1 and 2.

The timer is built around a three-state machine. IDLE means stopped: the counter and prescaler hold their values. RUN means counting. EXPIRED is terminal. The transitions are:

- IDLE to RUN when the enable bit is set.
- RUN to IDLE when the enable bit is cleared.
- RUN to EXPIRED when a prescaler tick arrives with the counter at 1 or 0 and no reload happens in the same cycle.
- EXPIRED to EXPIRED until reset.

In EXPIRED the reset request is driven high. Timeout in clock cycles equals reload count times (prescaler field + 1).

Top module: `keyed_wdog`

## Requirements
- R1: A write is accepted only when wdata[31:16] equals 16'h1234. Any other write changes no register and fires no refresh group.
- R2: Byte offsets are: 0x04 prescaler setting, 0x08 reload count, 0x0C warning level, 0x18 refresh codes, 0x1C control. A read returns the stored 16-bit value in bits 15:0 with bits 31:16 zero. The refresh register reads as its last accepted 6-bit code. An unmapped offset reads as zero.
- R3: Values written to offsets 0x04, 0x08 and 0x0C are held in shadows and have no effect on timing until their refresh group fires.
- R4: Refresh bits 5:4 apply the prescaler shadow. Bits 3:2 reload the counter from the reload shadow and restart the prescaler. Bits 1:0 apply the warning shadow. A group fires only when its written code differs from its stored code, so rewriting the same code does nothing. All codes reset to 0.
- R5: Bits 15:8 of the prescaler setting hold n, and the counter decrements once every n+1 clocks. After reset, n is 15, the reload count is 0xFFFF and the warning level is 0.
- R6: Control bit 0 starts counting. If control bit 0 is written to 1 at clock edge W, rst_req first reads high after edge W+1+max(N,1)*(n+1), where N is the active count.
- R7: Writing control bit 0 to 0 stops the count. The count freezes at its value and resumes from there when the bit is set again.
- R8: rst_req is sticky. Once high it stays high until rst_n, whatever is written afterwards.
- R9: warn is high only in RUN, and only while the active count is at or below the applied warning level.
- R10: After reset, rst_req and warn are low and every register reads its reset value. The control and refresh registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 5 | Byte offset of the access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data: key in 31:16, value in 15:0 |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| rst_req | output | 1 | Sticky expiry reset request |
| warn | output | 1 | Early-warning flag |

## Verification
The assertions assume that bus_we is a single-cycle strobe and that address and data are valid whenever it is high. They also assume the inputs carry no unknowns once reset is released. The stimulus changes inputs only on the falling edge and drops the strobe after one rising edge. It also re-applies reset before every timing measurement, because expiry is sticky.

// File: rtl/keyed_wdog_pkg.sv
package keyed_wdog_pkg;
    localparam logic [15:0] UNLOCK_KEY = 16'h1234;

    localparam int OFS_PRESCALE = 'h04;
    localparam int OFS_RELOAD   = 'h08;
    localparam int OFS_WARN     = 'h0C;
    localparam int OFS_REFRESH  = 'h18;
    localparam int OFS_CONTROL  = 'h1C;

    localparam int NUM_GROUPS = 3;
    localparam int GRP_WARN   = 0;
    localparam int GRP_COUNT  = 1;
    localparam int GRP_PRESC  = 2;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RUN     = 2'd1,
        ST_EXPIRED = 2'd2
    } wd_state_e;
endpackage

// File: rtl/keyed_wdog_regs.sv
module keyed_wdog_regs
    import keyed_wdog_pkg::*;
#(
    parameter int ADDR_W  = 5,
    parameter int VAL_W   = 16,
    parameter int PRE_W   = 8,
    parameter int PRE_RST = 15
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic                  bus_we,
    input  logic [31:0]           bus_wdata,
    output logic [31:0]           bus_rdata,
    output logic                  run_en,
    output logic [NUM_GROUPS-1:0] fire,
    output logic [PRE_W-1:0]      div_new,
    output logic [VAL_W-1:0]      load_new,
    output logic [VAL_W-1:0]      warn_new
);
    localparam int CODE_W = 2 * NUM_GROUPS;

    logic [VAL_W-1:0]  presc_sh, reload_sh, warn_sh, ctrl_q;
    logic [CODE_W-1:0] codes_q;
    logic              key_ok, wr_ok;

    assign key_ok = (bus_wdata[31:16] == UNLOCK_KEY);
    assign wr_ok  = bus_we && key_ok;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            presc_sh  <= VAL_W'(PRE_RST << 8);
            reload_sh <= '1;
            warn_sh   <= '0;
            ctrl_q    <= '0;
            codes_q   <= '0;
        end else if (wr_ok) begin
            if (bus_addr == ADDR_W'(OFS_PRESCALE)) presc_sh  <= bus_wdata[VAL_W-1:0];
            if (bus_addr == ADDR_W'(OFS_RELOAD))   reload_sh <= bus_wdata[VAL_W-1:0];
            if (bus_addr == ADDR_W'(OFS_WARN))     warn_sh   <= bus_wdata[VAL_W-1:0];
            if (bus_addr == ADDR_W'(OFS_CONTROL))  ctrl_q    <= bus_wdata[VAL_W-1:0];
            if (bus_addr == ADDR_W'(OFS_REFRESH))  codes_q   <= bus_wdata[CODE_W-1:0];
        end
    end

    // Per-group change detection on accepted refresh writes.
    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        assign fire[g] = wr_ok && (bus_addr == ADDR_W'(OFS_REFRESH)) &&
                         (bus_wdata[2*g +: 2] != codes_q[2*g +: 2]);
    end

    assign run_en   = ctrl_q[0];
    assign div_new  = presc_sh[8 +: PRE_W];
    assign load_new = reload_sh;
    assign warn_new = warn_sh;

    always_comb begin
        bus_rdata = '0;
        unique case (int'(bus_addr))
            OFS_PRESCALE: bus_rdata[VAL_W-1:0]  = presc_sh;
            OFS_RELOAD:   bus_rdata[VAL_W-1:0]  = reload_sh;
            OFS_WARN:     bus_rdata[VAL_W-1:0]  = warn_sh;
            OFS_CONTROL:  bus_rdata[VAL_W-1:0]  = ctrl_q;
            OFS_REFRESH:  bus_rdata[CODE_W-1:0] = codes_q;
            default:      bus_rdata = '0;
        endcase
    end

    // R1: a write with a wrong key leaves every register untouched
    p_badkey_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !key_ok) |=> ($stable(presc_sh) && $stable(reload_sh) &&
                                 $stable(warn_sh) && $stable(ctrl_q) && $stable(codes_q)));

    // R4: stored codes only move on an accepted refresh write
    p_codes_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_ok && bus_addr == ADDR_W'(OFS_REFRESH)) |=> $stable(codes_q));
endmodule

// File: rtl/keyed_wdog_core.sv
module keyed_wdog_core
    import keyed_wdog_pkg::*;
#(
    parameter int VAL_W   = 16,
    parameter int PRE_W   = 8,
    parameter int PRE_RST = 15
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  run_en,
    input  logic [NUM_GROUPS-1:0] fire,
    input  logic [PRE_W-1:0]      div_new,
    input  logic [VAL_W-1:0]      load_new,
    input  logic [VAL_W-1:0]      warn_new,
    output logic                  rst_req,
    output logic                  warn
);
    wd_state_e        state_q, state_d;
    logic [PRE_W-1:0] div_q, pre_q;
    logic [VAL_W-1:0] cnt_q, warn_q;
    logic             tick, last;

    assign tick = (state_q == ST_RUN) && (pre_q == div_q);
    assign last = (cnt_q <= VAL_W'(1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (run_en) state_d = ST_RUN;
            ST_RUN: begin
                if (tick && last && !fire[GRP_COUNT]) state_d = ST_EXPIRED;
                else if (!run_en)                     state_d = ST_IDLE;
            end
            ST_EXPIRED: state_d = ST_EXPIRED;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q  <= PRE_W'(PRE_RST);
            pre_q  <= '0;
            cnt_q  <= '1;
            warn_q <= '0;
        end else begin
            if (fire[GRP_WARN]) warn_q <= warn_new;
            if (fire[GRP_PRESC]) div_q <= div_new;
            if (state_q != ST_EXPIRED && (fire[GRP_COUNT] || fire[GRP_PRESC]))
                pre_q <= '0;
            else if (state_q == ST_RUN)
                pre_q <= tick ? '0 : pre_q + 1'b1;
            if (state_q != ST_EXPIRED && fire[GRP_COUNT])
                cnt_q <= load_new;
            else if (tick)
                cnt_q <= last ? '0 : cnt_q - 1'b1;
        end
    end

    always_comb begin
        rst_req = (state_q == ST_EXPIRED);
        warn    = (state_q == ST_RUN) && (cnt_q <= warn_q);
    end

    // R8: expiry is terminal until reset
    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> rst_req);
    // R7: a stopped counter holds its value
    p_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !fire[GRP_COUNT]) |=> $stable(cnt_q));
    // R5: the prescaler never passes the applied divisor
    p_pre_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pre_q <= div_q);
    // R6: each tick removes exactly one from a count above one
    p_dec_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !last && !fire[GRP_COUNT]) |=> (cnt_q == $past(cnt_q) - 1'b1));
    // R4: counter group loads the reload shadow
    p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fire[GRP_COUNT] && state_q != ST_EXPIRED) |=> (cnt_q == $past(load_new)));
endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
    import keyed_wdog_pkg::*;
#(
    parameter int ADDR_W  = 5,
    parameter int VAL_W   = 16,
    parameter int PRE_W   = 8,
    parameter int PRE_RST = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              rst_req,
    output logic              warn
);
    logic                  run_en;
    logic [NUM_GROUPS-1:0] fire;
    logic [PRE_W-1:0]      div_new;
    logic [VAL_W-1:0]      load_new, warn_new;

    keyed_wdog_regs #(.ADDR_W(ADDR_W), .VAL_W(VAL_W), .PRE_W(PRE_W), .PRE_RST(PRE_RST)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .run_en(run_en),
        .fire(fire), .div_new(div_new), .load_new(load_new), .warn_new(warn_new)
    );

    keyed_wdog_core #(.VAL_W(VAL_W), .PRE_W(PRE_W), .PRE_RST(PRE_RST)) u_core (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .fire(fire),
        .div_new(div_new), .load_new(load_new), .warn_new(warn_new),
        .rst_req(rst_req), .warn(warn)
    );
endmodule

// File: tb/keyed_wdog_bench.sv
`timescale 1ns/1ps
module keyed_wdog_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rst_req, warn;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;

    localparam logic [15:0] KEY = 16'h1234;

    always #2 clk = ~clk;

    keyed_wdog u_keyed_wdog (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rst_req(rst_req), .warn(warn)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_bad++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 100000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic check(input string tag, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        bus_we = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input int ofs, input logic [15:0] val, input logic [15:0] key);
        @(negedge clk);
        bus_addr = 5'(ofs);
        bus_wdata = {key, val};
        bus_we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input int ofs, output logic [31:0] v);
        @(negedge clk);
        bus_addr = 5'(ofs);
        #1 v = bus_rdata;
    endtask

    // Counts rising edges after the write edge until rst_req reads high.
    task automatic measure(output int c);
        c = 0;
        for (int i = 0; i < 400; i++) begin
            @(posedge clk);
            c++;
            @(negedge clk);
            if (rst_req) break;
        end
        if (!rst_req) c = 999;
    endtask

    task automatic setup(input int n, input int cnt, input logic [5:0] codes);
        wr('h04, 16'(n << 8), KEY);
        wr('h08, 16'(cnt), KEY);
        wr('h18, 16'(codes), KEY);
    endtask

    initial begin
        logic [31:0] v;
        int c;
        do_reset();

        // R10 and R5 reset state
        check("R10 rst_req", rst_req, 0);
        check("R10 warn", warn, 0);
        rd('h04, v); check("R5 prescale reset", v, 32'h0F00);
        rd('h08, v); check("R5 reload reset", v, 32'hFFFF);
        rd('h0C, v); check("R5 warn reset", v, 0);
        rd('h18, v); check("R10 refresh reset", v, 0);
        rd('h1C, v); check("R10 control reset", v, 0);

        // R1 wrong key ignored
        wr('h08, 16'h0042, 16'h4321);
        rd('h08, v); check("R1 badkey reload", v, 32'hFFFF);
        wr('h18, 16'h003F, 16'h1235);
        rd('h18, v); check("R1 badkey refresh", v, 0);
        wr('h1C, 16'h0001, 16'h0000);
        repeat (20) @(posedge clk);
        @(negedge clk);
        check("R1 badkey start", warn | rst_req, 0);

        // R2 readback and upper zero
        wr('h04, 16'h0300, KEY); rd('h04, v); check("R2 prescale rd", v, 32'h0300);
        wr('h0C, 16'hABCD, KEY); rd('h0C, v); check("R2 warn rd", v, 32'hABCD);
        wr('h18, 16'hFF15, KEY); rd('h18, v); check("R2 refresh rd", v, 32'h15);
        wr('h1C, 16'h8000, KEY); rd('h1C, v); check("R2 control rd", v, 32'h8000);
        rd('h00, v); check("R2 unmapped", v, 0);

        // R5 R6 sweep of divisor and count
        for (int n = 0; n < 4; n++) begin
            for (int k = 0; k < 4; k++) begin
                int cnt;
                int exp;
                cnt = (k == 3) ? 5 : k;
                exp = 1 + ((cnt < 1) ? 1 : cnt) * (n + 1);
                do_reset();
                setup(n, cnt, 6'h15);
                wr('h1C, 16'h0001, KEY);
                measure(c);
                check($sformatf("R6 expiry n=%0d N=%0d", n, cnt), c, exp);
            end
        end

        // R3 shadow only; R4 same code is a no-op
        do_reset();
        setup(0, 3, 6'h15);
        wr('h08, 16'd7, KEY);
        wr('h18, 16'h15, KEY);
        wr('h1C, 16'h0001, KEY);
        measure(c);
        check("R3 R4 shadow held", c, 4);

        // R4 only the counter group flips
        do_reset();
        setup(0, 3, 6'h15);
        wr('h08, 16'd7, KEY);
        wr('h18, 16'h19, KEY);
        wr('h1C, 16'h0001, KEY);
        measure(c);
        check("R4 counter group", c, 8);

        // R4 prescaler group untouched -> default divide by 16
        do_reset();
        wr('h04, 16'h0300, KEY);
        wr('h08, 16'd2, KEY);
        wr('h18, 16'h04, KEY);
        wr('h1C, 16'h0001, KEY);
        measure(c);
        check("R4 presc group idle", c, 33);

        // R9 warning level
        do_reset();
        wr('h0C, 16'd2, KEY);
        setup(0, 4, 6'h15);
        wr('h1C, 16'h0001, KEY);
        @(posedge clk); @(negedge clk);
        check("R9 warn low cnt=4", warn, 0);
        @(posedge clk); @(negedge clk);
        check("R9 warn low cnt=3", warn, 0);
        @(posedge clk); @(negedge clk);
        check("R9 warn high cnt=2", warn, 1);

        // R7 stop and resume
        do_reset();
        setup(0, 6, 6'h15);
        wr('h1C, 16'h0001, KEY);
        @(posedge clk); @(posedge clk);
        wr('h1C, 16'h0000, KEY);
        repeat (50) @(posedge clk);
        @(negedge clk);
        check("R7 stopped no expiry", rst_req, 0);
        wr('h1C, 16'h0001, KEY);
        measure(c);
        check("R7 resume remaining", c, 4);

        // R8 sticky
        wr('h08, 16'd100, KEY);
        wr('h18, 16'h2A, KEY);
        wr('h1C, 16'h0000, KEY);
        repeat (20) @(posedge clk);
        @(negedge clk);
        check("R8 sticky", rst_req, 1);
        do_reset();
        check("R8 cleared by reset", rst_req, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule